// File: doc/BRIEF.md
# Dual-Mode Clock Frequency Scaler

This block turns a fast clock into a lower-rate single-cycle enable strobe. Logic that runs on the fast clock can then work at a reduced rate without a second clock. A small control word is written through a one-cycle write port. The word holds a 3-bit scale field, a mode bit and a gate bit. The effective scale is N = field + 1, so N ranges from 1 to 8.

The mode bit selects how the field is read. In the fractional reading, N strobes are let through out of every eight input cycles. They are spread evenly by a modulo-8 accumulator. In the integer reading, the input rate is divided by N. A parameter can build the block without the mode bit, and such an instance always uses the fractional reading.

A sequencer FSM has three states: OFF, FRAC and INT. Every transition happens at a boundary. In OFF, every cycle is a boundary. In FRAC, the boundary is the last cycle of an eight-cycle window. In INT, the boundary is the cycle in which the down-counter fires. At a boundary, the FSM latches the pending word and moves to the next state:
- OFF when the gate bit is clear.
- INT when the gate bit is set and the integer reading is selected.
- FRAC otherwise.

Away from a boundary, the FSM stays in its state.

Top module: `clk_scaler_top`

## Requirements
- R1: The control word places the scale field in bits [2:0], the mode bit in bit 3 and the gate bit in bit 4. The effective scale is N = field + 1.
- R2: In FRAC (mode bit 0), exactly N strobes appear in any eight consecutive input cycles.
- R3: In FRAC, strobes are spread evenly: no gap between consecutive strobes exceeds ceil(8/N) cycles.
- R4: In INT (mode bit 1), exactly one strobe appears every N cycles. With N = 1 the strobe is high on every cycle.
- R5: In FRAC with field value 7, the strobe is high on every input cycle.
- R6: With the gate bit clear, no strobe is produced once the current window or period has ended.
- R7: An instance built without the mode bit ignores bit 3 and always behaves as in FRAC.
- R8: A word written in the middle of a period takes effect only at the next boundary. The period in progress finishes at its old length, with no runt period.
- R9: Synchronous active-high reset does four things: it puts the FSM in OFF, clears the accumulator and counter, loads a pending field of 7 with mode 0, and clears the gate. The strobe stays low until a word with the gate set is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | SCALE_W+2 | Control word: field, mode bit, gate bit |
| scale_ce | output | 1 | Single-cycle enable strobe at the scaled rate |

## Verification
The bench writes every field value in both readings. It counts strobes over 16·8·N cycles, a span that is a whole number of periods for both readings, so the two readings of the same field give different counts. Within each window it also records the longest gap between strobes, which separates an evenly spread fractional pattern from a bunched one.

A second instance without the mode bit gets the same writes. Its counts show whether bit 3 is ignored. A mid-period rewrite from divide-by-8 to divide-by-2 measures the two following gaps to check that boundary changes take effect without a runt period. A cleared gate and the idle time after reset are both checked for silence.

// File: rtl/cs_pkg.sv
package cs_pkg;
    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_FRAC = 2'd1,
        S_INT  = 2'd2
    } cs_state_e;
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg #(
    parameter int SCALE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SCALE_W+1:0] wdata,
    output logic [SCALE_W-1:0] field,
    output logic               mode,
    output logic               gate
);
    // Pending word, taken up by the sequencer only at a boundary (R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            field <= '1;      // R9: full-rate field, fractional mode, gate off
            mode  <= 1'b0;
            gate  <= 1'b0;
        end else if (we) begin
            field <= wdata[SCALE_W-1:0];
            mode  <= wdata[SCALE_W];
            gate  <= wdata[SCALE_W+1];
        end
    end
endmodule

// File: rtl/cs_frac_acc.sv
module cs_frac_acc #(
    parameter int SCALE_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [SCALE_W:0] n,
    output logic             fire,
    output logic             last
);
    logic [SCALE_W-1:0] acc;
    logic [SCALE_W-1:0] phase;
    logic [SCALE_W:0]   sum;

    assign sum  = {1'b0, acc} + n;
    assign fire = run && sum[SCALE_W];   // carry out of the window modulus
    assign last = run && (&phase);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc   <= '0;
            phase <= '0;
        end else if (run) begin
            acc   <= sum[SCALE_W-1:0];
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/cs_int_cnt.sv
module cs_int_cnt #(
    parameter int SCALE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [SCALE_W-1:0] load_val,
    input  logic               run,
    output logic               fire,
    output logic [SCALE_W-1:0] cnt
);
    assign fire = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/clk_scaler_top.sv
module clk_scaler_top
    import cs_pkg::*;
#(
    parameter int SCALE_W  = 3,
    parameter int HAS_MODE = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SCALE_W+1:0] cfg_wdata,
    output logic               scale_ce
);
    localparam int N_W = SCALE_W + 1;

    logic [SCALE_W-1:0] pend_field;
    logic               pend_mode;
    logic               pend_gate;
    logic [SCALE_W-1:0] act_field;
    logic [N_W-1:0]     act_n;
    logic               want_int;
    logic               bound;
    logic               frac_fire, frac_last;
    logic               int_fire;
    logic [SCALE_W-1:0] int_cnt;
    cs_state_e          state_q, state_d;

    cs_cfg_reg #(.SCALE_W(SCALE_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .field(pend_field), .mode(pend_mode), .gate(pend_gate)
    );

    generate
        if (HAS_MODE != 0) begin : g_mode
            assign want_int = pend_mode;
        end else begin : g_nomode
            assign want_int = 1'b0;   // R7: bit 3 has no effect
        end
    endgenerate

    assign act_n = {1'b0, act_field} + 1'b1;

    cs_frac_acc #(.SCALE_W(SCALE_W)) u_frac (
        .clk(clk), .rst(rst), .clear(bound), .run(state_q == S_FRAC),
        .n(act_n), .fire(frac_fire), .last(frac_last)
    );

    cs_int_cnt #(.SCALE_W(SCALE_W)) u_int (
        .clk(clk), .rst(rst), .load(bound), .load_val(pend_field),
        .run(state_q == S_INT), .fire(int_fire), .cnt(int_cnt)
    );

    // Boundary detection and next-state logic
    always_comb begin
        unique case (state_q)
            S_OFF:   bound = 1'b1;
            S_FRAC:  bound = frac_last;
            S_INT:   bound = int_fire;
            default: bound = 1'b1;
        endcase
        state_d = state_q;
        if (bound) begin
            if (!pend_gate)    state_d = S_OFF;
            else if (want_int) state_d = S_INT;
            else               state_d = S_FRAC;
        end
    end

    // State register and active field latch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_OFF;
            act_field <= '1;
        end else begin
            state_q <= state_d;
            if (bound) act_field <= pend_field;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            S_OFF:   scale_ce = 1'b0;
            S_FRAC:  scale_ce = frac_fire;
            S_INT:   scale_ce = int_fire;
            default: scale_ce = 1'b0;
        endcase
    end
endmodule

// File: rtl/cs_checker.sv
module cs_checker
    import cs_pkg::*;
#(
    parameter int SCALE_W  = 3,
    parameter int HAS_MODE = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               ce,
    input logic               bound,
    input logic               pend_gate,
    input cs_state_e          state,
    input logic [SCALE_W-1:0] int_cnt,
    input logic [SCALE_W-1:0] act_field
);
    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        state == S_OFF |-> !ce);

    assert_gate_drop_R6: assert property (@(posedge clk) disable iff (rst)
        bound && !pend_gate |=> state == S_OFF);

    assert_reset_off_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state == S_OFF && !ce);

    assert_int_silent_R4: assert property (@(posedge clk) disable iff (rst)
        state == S_INT && int_cnt != '0 |-> !ce);

    assert_int_step_R4: assert property (@(posedge clk) disable iff (rst)
        state == S_INT && int_cnt != '0 |=> int_cnt == $past(int_cnt) - 1'b1);

    assert_hold_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        !bound |=> $stable(act_field) && $stable(state));

    assert_no_int_R7: assert property (@(posedge clk) disable iff (rst)
        HAS_MODE == 0 |-> state != S_INT);

    assert_full_rate_R5: assert property (@(posedge clk) disable iff (rst)
        state == S_FRAC && act_field == '1 |-> ce);
endmodule

bind clk_scaler_top cs_checker #(.SCALE_W(SCALE_W), .HAS_MODE(HAS_MODE)) u_chk (
    .clk(clk), .rst(rst), .ce(scale_ce), .bound(bound), .pend_gate(pend_gate),
    .state(state_q), .int_cnt(int_cnt), .act_field(act_field)
);

// File: tb/sim_clk_scaler_top.sv
`timescale 1ns/1ps
module sim_clk_scaler_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       ce0, ce1;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;

    typedef struct {
        int    len;
        int    exp0;
        int    gap0;
        int    exp1;
        string req0;
        string reqg;
        string req1;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    clk_scaler_top #(.SCALE_W(3), .HAS_MODE(1)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .scale_ce(ce0));
    clk_scaler_top #(.SCALE_W(3), .HAS_MODE(0)) u1 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .scale_ce(ce1));

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1: field bits [2:0], mode bit 3, gate bit 4
    task automatic wr(bit gate, bit mode, int field);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {gate, mode, field[2:0]};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic push_and_wait(item_t it);
        int target;
        target = done_cnt + 1;
        q.push_back(it);
        wait (done_cnt == target);
    endtask

    // Monitor: pops expected items and measures the strobes over the window
    initial begin
        forever begin
            item_t it;
            int c0, c1, maxg, last;
            bit seen;
            wait (q.size() != 0);
            it = q.pop_front();
            c0 = 0; c1 = 0; maxg = 0; last = 0; seen = 1'b0;
            for (int i = 0; i < it.len; i++) begin
                @(negedge clk);
                if (ce0) begin
                    c0++;
                    if (seen && (i - last) > maxg) maxg = i - last;
                    last = i;
                    seen = 1'b1;
                end
                if (ce1) c1++;
            end
            chk(it.req0, "strobe count u0", c0, it.exp0);
            chk(it.req1, "strobe count u1", c1, it.exp1);
            if (it.gap0 > 0) begin
                checks++;
                if (maxg > it.gap0) begin
                    fails++;
                    $display("FAIL %s max gap: actual %0d expected <= %0d", it.reqg, maxg, it.gap0);
                end
            end
            done_cnt++;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Driver
    initial begin
        int t;
        int quiet;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9: after reset, no strobes until a word with the gate bit set is written
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ce0 || ce1) quiet++;
        end
        chk("R9", "strobes after reset", quiet, 0);

        // R2 R3 R4 R5 R7: every field in both readings
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 8; f++) begin
                item_t it;
                int n;
                n = f + 1;
                wr(1'b1, m[0], f);
                repeat (12) @(negedge clk);
                it.len  = 128 * n;
                it.exp1 = 16 * n * n;
                if (m == 0) begin
                    it.exp0 = 16 * n * n;
                    it.gap0 = (8 + n - 1) / n;
                    it.req0 = (f == 7) ? "R5/R2/R1" : "R2/R1";
                    it.reqg = "R3";
                    it.req1 = "R2";
                end else begin
                    it.exp0 = 128;
                    it.gap0 = n;
                    it.req0 = "R4/R1";
                    it.reqg = "R4";
                    it.req1 = "R7";
                end
                push_and_wait(it);
            end
        end

        // R8: mid-period change from divide-by-8 to divide-by-2
        wr(1'b1, 1'b1, 7);
        repeat (12) @(negedge clk);
        t = 0;
        while (!ce0 && t < 20) begin @(negedge clk); t++; end
        t = 0;
        @(negedge clk); t++;
        @(negedge clk); t++;
        @(negedge clk); t++;
        cfg_we = 1'b1; cfg_wdata = {1'b1, 1'b1, 3'd1};
        @(negedge clk); t++;
        cfg_we = 1'b0;
        while (!ce0 && t < 20) begin @(negedge clk); t++; end
        chk("R8", "gap of period in progress", t, 8);
        t = 0;
        @(negedge clk); t++;
        while (!ce0 && t < 20) begin @(negedge clk); t++; end
        chk("R8", "gap after boundary", t, 2);

        // R6: gate cleared
        begin
            item_t it;
            wr(1'b0, 1'b0, 3);
            repeat (12) @(negedge clk);
            it.len = 128; it.exp0 = 0; it.gap0 = 0; it.exp1 = 0;
            it.req0 = "R6"; it.reqg = "R6"; it.req1 = "R6";
            push_and_wait(it);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule